// File: doc/BRIEF.md
# Window-Comparator Alarm Status Controller

This block watches the results of a multichannel conversion engine and raises an alarm when a result falls outside a programmable window. It takes five external channel results and one temperature result. Each result is 12 bits wide and comes with its own valid strobe, and each strobe marks one monitoring cycle for that channel. Each channel has its own lower and upper threshold. The temperature channel reports the two sides of its window as two separate alarm sources. An external alarm input is also sampled every clock as a further source.

Every source owns one bit in a status word, and the word carries a global flag that is set while any source bit is set. The host sets the sticky behaviour with one control bit. In latched mode a raised bit holds until the host reads the status word, and the read clears it. In transparent mode a bit follows the last comparison result. The external alarm input bypasses all latching. Per-source masks keep a source from driving the interrupt, but the source's status bit is still set. The interrupt also requires a global enable bit.

The host reaches all registers through a simple port. Writes are synchronous. Read data is combinational from the address. A read strobe on the status address clears the latched bits.

Top module: `win_alarm_ctrl`

## Requirements
- R1: Register map. Lower thresholds are at addresses 0..5 and upper thresholds at 8..13, where channel 5 is temperature. The control register is at 16, with bit 0 as latch-disable and bit 1 as interrupt enable. The mask register is at 17, with bits 7..0, one per source. The status register is at 18. After reset every lower threshold reads 0x000, every upper threshold reads 0xFFF, control reads 0, mask reads 0x00FF, status reads 0 and the interrupt is low.
- R2: A valid result on external channel c (0..4) is out of range only when it is strictly below its lower threshold or strictly above its upper threshold. An out-of-range result sets status bit c. A value equal to either threshold is in range. Comparisons are unsigned.
- R3: A valid temperature result above its upper threshold sets status bit 5. A valid temperature result below its lower threshold sets status bit 6.
- R4: With latch-disable at 0, a raised status bit for sources 0..6 stays set after later in-range results until the status register is read.
- R5: A read of the status register (read strobe at address 18) returns the current word and clears bits 0..6 in latched mode. The next out-of-range valid result sets the bit again.
- R6: If a status read and a new out-of-range valid result for a source fall in the same clock, that source's bit is set after the clock. Other latched bits are cleared.
- R7: With latch-disable at 1, each of bits 0..6 takes the result of its latest valid comparison, so it drops on an in-range result. A status read does not clear these bits.
- R8: Status bit 7 equals the external alarm input one clock earlier, in either mode, and a status read never clears it.
- R9: Status bit 15 (the global flag) is set exactly when any of bits 7..0 is set. It clears together with them.
- R10: The interrupt output is high exactly when the interrupt enable is set and some status bit is set whose mask bit is 0. Mask bits never change the status word.
- R11: With the interrupt enable at 0, the interrupt output stays low whatever the status and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_data | input | 60 | Five external results, channel c at bits 12c+11..12c |
| ext_valid | input | 5 | Per-channel result strobe |
| temp_data | input | 12 | Temperature result |
| temp_valid | input | 1 | Temperature result strobe |
| alarm_in | input | 1 | External alarm level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status at address 18) |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| irq | output | 1 | Active-high interrupt |

## Verification
A host clear-on-read and a fresh out-of-range result on a channel can land on the same clock edge. In that case the event has to win for its own bit, while every other latched bit still clears. The bench provokes this by raising the read strobe while it presents an out-of-range result on one channel, with a different channel already latched. It expects the read to return the old word and the status afterwards to hold only the new source. The same clash in transparent mode, and the alarm input sampled across a read, check that a read cannot remove a bit that the rules keep set.

// File: rtl/win_alarm_pkg.sv
// Package: shared register addresses, field positions and the control type
// for the window-comparator alarm controller.
package win_alarm_pkg;
    localparam int REG_W       = 16;  // host data width
    localparam int ADDR_W      = 5;   // host address width
    localparam int ADR_LO_BASE = 0;   // lower thresholds, one per channel
    localparam int ADR_HI_BASE = 8;   // upper thresholds, one per channel
    localparam int ADR_CTRL    = 16;  // control register
    localparam int ADR_MASK    = 17;  // interrupt mask register
    localparam int ADR_STAT    = 18;  // status register, clear on read
    localparam int GLOBAL_BIT  = 15;  // global alarm flag within status word

    // Control register, bit 1 = interrupt enable, bit 0 = latch disable.
    typedef struct packed {
        logic irq_en;
        logic latch_dis;
    } wa_ctrl_t;
endpackage

// File: rtl/wa_cmp_bank.sv
// Module: wa_cmp_bank
// Purpose: one strict unsigned window comparator per channel.
// Assumes: thresholds are stable register outputs; results are combinational.
module wa_cmp_bank #(
    parameter int NCH    = 6,
    parameter int DATA_W = 12
) (
    input  logic [NCH-1:0][DATA_W-1:0] data,
    input  logic [NCH-1:0][DATA_W-1:0] lo_thr,
    input  logic [NCH-1:0][DATA_W-1:0] hi_thr,
    output logic [NCH-1:0]             below,
    output logic [NCH-1:0]             above
);
    // One comparator pair per channel; equality counts as in range.
    for (genvar c = 0; c < NCH; c++) begin : g_cmp
        assign below[c] = data[c] < lo_thr[c];
        assign above[c] = data[c] > hi_thr[c];
    end
endmodule

// File: rtl/wa_regfile.sv
// Module: wa_regfile
// Purpose: host-visible threshold, control and mask registers plus the
// read-data mux and the clear-on-read strobe for the status word.
// Assumes: single-cycle write strobe; read data is combinational from address.
module wa_regfile
    import win_alarm_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int DATA_W = 12,
    parameter int NSRC   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [REG_W-1:0]           reg_wdata,
    input  logic [NSRC-1:0]            status,
    input  logic                       any_alarm,
    output logic [REG_W-1:0]           reg_rdata,
    output logic [NCH-1:0][DATA_W-1:0] lo_thr,
    output logic [NCH-1:0][DATA_W-1:0] hi_thr,
    output logic [NSRC-1:0]            mask,
    output wa_ctrl_t                   ctrl,
    output logic                       rd_clr
);
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[REG_W-1:DATA_W];

    // Register writes; reset opens every window fully and masks every source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_thr <= '0;
            hi_thr <= '1;
            mask   <= '1;
            ctrl   <= '0;
        end else if (reg_wr) begin
            for (int c = 0; c < NCH; c++) begin
                if (reg_addr == ADDR_W'(ADR_LO_BASE + c)) lo_thr[c] <= reg_wdata[DATA_W-1:0];
                if (reg_addr == ADDR_W'(ADR_HI_BASE + c)) hi_thr[c] <= reg_wdata[DATA_W-1:0];
            end
            if (reg_addr == ADDR_W'(ADR_CTRL)) ctrl <= wa_ctrl_t'(reg_wdata[1:0]);
            if (reg_addr == ADDR_W'(ADR_MASK)) mask <= reg_wdata[NSRC-1:0];
        end
    end

    // Clear strobe for the status word.
    assign rd_clr = reg_rd && (reg_addr == ADDR_W'(ADR_STAT));

    // Read-data mux over all registers.
    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (reg_addr == ADDR_W'(ADR_LO_BASE + c)) reg_rdata[DATA_W-1:0] = lo_thr[c];
            if (reg_addr == ADDR_W'(ADR_HI_BASE + c)) reg_rdata[DATA_W-1:0] = hi_thr[c];
        end
        if (reg_addr == ADDR_W'(ADR_CTRL)) reg_rdata[1:0] = ctrl;
        if (reg_addr == ADDR_W'(ADR_MASK)) reg_rdata[NSRC-1:0] = mask;
        if (reg_addr == ADDR_W'(ADR_STAT)) begin
            reg_rdata[NSRC-1:0]  = status;
            reg_rdata[GLOBAL_BIT] = any_alarm;
        end
    end
endmodule

// File: rtl/wa_status.sv
// Module: wa_status
// Purpose: per-source alarm status flops with latched/transparent behaviour.
// Assumes: source NSRC-1 is the external alarm level and is never latched;
// sources below it update only when their strobe is high.
module wa_status #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            latch_dis,
    input  logic            rd_clr,
    input  logic [NSRC-2:0] upd,
    input  logic [NSRC-2:0] evt,
    input  logic            alarm_in,
    output logic [NSRC-1:0] status,
    output logic            any_alarm
);
    for (genvar i = 0; i < NSRC - 1; i++) begin : g_src
        // Status bit update; a new event beats a same-cycle clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[i] <= 1'b0;
            end else if (latch_dis) begin
                if (upd[i]) status[i] <= evt[i];
            end else if (upd[i] && evt[i]) begin
                status[i] <= 1'b1;
            end else if (rd_clr) begin
                status[i] <= 1'b0;
            end
        end
    end

    // External alarm bit follows its input, unaffected by reads or mode.
    always_ff @(posedge clk) begin
        if (!rst_n) status[NSRC-1] <= 1'b0;
        else        status[NSRC-1] <= alarm_in;
    end

    assign any_alarm = |status;
endmodule

// File: rtl/win_alarm_ctrl.sv
// Module: win_alarm_ctrl (top)
// Purpose: monitors N_EXT external results and one temperature result against
// per-channel windows, keeps an alarm status word and drives an interrupt.
// Assumes: N_EXT + 1 <= 8 channels and N_EXT + 3 <= 15 sources so the fixed
// register map holds them; DATA_W < 16.
module win_alarm_ctrl
    import win_alarm_pkg::*;
#(
    parameter int N_EXT  = 5,
    parameter int DATA_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_EXT*DATA_W-1:0] ext_data,
    input  logic [N_EXT-1:0]        ext_valid,
    input  logic [DATA_W-1:0]       temp_data,
    input  logic                    temp_valid,
    input  logic                    alarm_in,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    output logic                    irq
);
    localparam int NCH    = N_EXT + 1;  // temperature is the last channel
    localparam int NSRC   = N_EXT + 3;  // ext, temp high, temp low, alarm in
    localparam int T_CH   = N_EXT;
    localparam int SRC_TH = N_EXT;
    localparam int SRC_TL = N_EXT + 1;

    logic [NCH-1:0][DATA_W-1:0] cmp_data;
    logic [NCH-1:0][DATA_W-1:0] lo_w, hi_w;
    logic [NCH-1:0]             below_w, above_w;
    logic [NSRC-1:0]            status_w, mask_w;
    logic [NSRC-2:0]            evt_w, upd_w;
    logic                       any_w, rd_clr_w;
    wa_ctrl_t                   ctrl_w;

    assign cmp_data = {temp_data, ext_data};

    wa_cmp_bank #(.NCH(NCH), .DATA_W(DATA_W)) u_cmp (
        .data   (cmp_data),
        .lo_thr (lo_w),
        .hi_thr (hi_w),
        .below  (below_w),
        .above  (above_w)
    );

    // Map comparator outputs onto alarm sources.
    for (genvar c = 0; c < N_EXT; c++) begin : g_ext_src
        assign evt_w[c] = below_w[c] | above_w[c];
        assign upd_w[c] = ext_valid[c];
    end
    assign evt_w[SRC_TH] = above_w[T_CH];
    assign evt_w[SRC_TL] = below_w[T_CH];
    assign upd_w[SRC_TH] = temp_valid;
    assign upd_w[SRC_TL] = temp_valid;

    wa_status #(.NSRC(NSRC)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_dis (ctrl_w.latch_dis),
        .rd_clr    (rd_clr_w),
        .upd       (upd_w),
        .evt       (evt_w),
        .alarm_in  (alarm_in),
        .status    (status_w),
        .any_alarm (any_w)
    );

    wa_regfile #(.NCH(NCH), .DATA_W(DATA_W), .NSRC(NSRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status    (status_w),
        .any_alarm (any_w),
        .reg_rdata (reg_rdata),
        .lo_thr    (lo_w),
        .hi_thr    (hi_w),
        .mask      (mask_w),
        .ctrl      (ctrl_w),
        .rd_clr    (rd_clr_w)
    );

    // Interrupt: any unmasked status bit, gated by the enable.
    assign irq = ctrl_w.irq_en & (|(status_w & ~mask_w));
endmodule

// File: rtl/wa_checker.sv
// Module: wa_checker
// Purpose: temporal checks on the status word and interrupt, bound to the top.
// Assumes: synchronous active-low reset held from time zero.
module wa_checker #(
    parameter int NSRC = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            alarm_in,
    input logic            irq,
    input logic            irq_en,
    input logic            latch_dis,
    input logic            rd_clr,
    input logic [NSRC-1:0] status,
    input logic [NSRC-1:0] mask,
    input logic [NSRC-2:0] evt,
    input logic [NSRC-2:0] upd
);
    localparam logic [NSRC-1:0] LATCHABLE = {1'b0, {(NSRC-1){1'b1}}};

    logic [NSRC-1:0] hit, miss;
    assign hit  = {1'b0, evt & upd};
    assign miss = {1'b0, ~evt & upd};

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en); // R11
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(status & ~mask))); // R10
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_dis && !rd_clr) |=> ((LATCHABLE & $past(status) & ~status) == '0)); // R4
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> (($past(hit) & ~status) == '0)); // R6
    AST_TRANSPARENT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        latch_dis |=> (($past(miss) & status) == '0)); // R7
    AST_ALARMIN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (status[NSRC-1] == $past(alarm_in))); // R8
endmodule

bind win_alarm_ctrl wa_checker #(.NSRC(NSRC)) u_wa_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alarm_in  (alarm_in),
    .irq       (irq),
    .irq_en    (ctrl_w.irq_en),
    .latch_dis (ctrl_w.latch_dis),
    .rd_clr    (rd_clr_w),
    .status    (status_w),
    .mask      (mask_w),
    .evt       (evt_w),
    .upd       (upd_w)
);

// File: tb/win_alarm_ctrl_tb_top.sv
`timescale 1ns/1ps
module win_alarm_ctrl_tb_top;
    localparam int N_EXT = 5;
    localparam int DW    = 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N_EXT*DW-1:0] ext_data;
    logic [N_EXT-1:0]  ext_valid;
    logic [DW-1:0]     temp_data;
    logic              temp_valid;
    logic              alarm_in;
    logic              reg_wr, reg_rd;
    logic [4:0]        reg_addr;
    logic [15:0]       reg_wdata;
    logic [15:0]       reg_rdata;
    logic              irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [7:0]  em = '0;     // expected status bits 7..0
    logic [11:0] lo_t [6];
    logic [11:0] hi_t [6];

    always #2 clk = ~clk;

    win_alarm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ext_data(ext_data), .ext_valid(ext_valid),
        .temp_data(temp_data), .temp_valid(temp_valid), .alarm_in(alarm_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #0.5;
    endtask

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(int a, logic [15:0] d);
        reg_addr = 5'(a); reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic peek(int a, output logic [15:0] v);
        reg_addr = 5'(a);
        #0.1;
        v = reg_rdata;
    endtask

    task automatic rdclr(output logic [15:0] v);
        reg_addr = 5'd18; reg_rd = 1'b1;
        #0.1;
        v = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic feed(int ch, logic [11:0] v);
        if (ch < N_EXT) begin
            ext_data[ch*DW +: DW] = v; ext_valid[ch] = 1'b1;
        end else begin
            temp_data = v; temp_valid = 1'b1;
        end
        tick();
        ext_valid = '0; temp_valid = 1'b0;
    endtask

    function automatic logic [15:0] sw(logic [7:0] e);
        return {|e, 7'b0, e};
    endfunction

    task automatic chk_stat(string tag);
        logic [15:0] v;
        peek(18, v);
        chk(tag, v, sw(em));
    endtask

    task automatic chk_irq(string tag, logic exp);
        #0.1;
        chk(tag, {15'b0, irq}, {15'b0, exp});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [11:0] vals [8];
        rst_n = 1'b0; ext_data = '0; ext_valid = '0; temp_data = '0;
        temp_valid = 1'b0; alarm_in = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
        reg_addr = '0; reg_wdata = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset values
        for (int c = 0; c < 6; c++) begin
            peek(c, v);     chk("R1 lower reset", v, 16'h0000);
            peek(8 + c, v); chk("R1 upper reset", v, 16'h0FFF);
        end
        peek(16, v); chk("R1 ctrl reset", v, 16'h0000);
        peek(17, v); chk("R1 mask reset", v, 16'h00FF);
        chk_stat("R1 status reset");
        chk_irq("R1 irq reset", 1'b0);

        // R1: per-channel thresholds, written and read back
        for (int c = 0; c < 6; c++) begin
            lo_t[c] = 12'(12'h100 + c * 16);
            hi_t[c] = 12'(12'hE00 - c * 16);
            wr(c, {4'h0, lo_t[c]});
            wr(8 + c, {4'h0, hi_t[c]});
        end
        for (int c = 0; c < 6; c++) begin
            peek(c, v);     chk("R1 lower readback", v, {4'h0, lo_t[c]});
            peek(8 + c, v); chk("R1 upper readback", v, {4'h0, hi_t[c]});
        end

        // R2/R3/R9/R10: transparent sweep around every threshold
        wr(17, 16'h0000);
        wr(16, 16'h0003);
        for (int c = 0; c < 6; c++) begin
            vals[0] = 12'h000;         vals[1] = lo_t[c] - 12'd1;
            vals[2] = lo_t[c];         vals[3] = lo_t[c] + 12'd1;
            vals[4] = hi_t[c] - 12'd1; vals[5] = hi_t[c];
            vals[6] = hi_t[c] + 12'd1; vals[7] = 12'hFFF;
            for (int k = 0; k < 8; k++) begin
                feed(c, vals[k]);
                if (c < 5) begin
                    em[c] = (vals[k] < lo_t[c]) || (vals[k] > hi_t[c]);
                    chk_stat("R2 window ext");
                end else begin
                    em[5] = vals[k] > hi_t[c];
                    em[6] = vals[k] < lo_t[c];
                    chk_stat("R3 window temp");
                end
                chk_irq("R10 irq unmasked", |em);
            end
        end

        // R5: latched mode, read returns word and clears
        wr(16, 16'h0002);
        rdclr(v); chk("R5 read value", v, sw(em));
        em[6:0] = '0;
        chk_stat("R5 after clear");
        chk_irq("R9 irq after clear", 1'b0);

        // R4: latched bit holds through in-range results
        feed(0, 12'h050); em[0] = 1'b1; chk_stat("R4 set");
        feed(0, 12'h200); chk_stat("R4 hold after in-range");
        feed(0, 12'h100); chk_stat("R4 hold at threshold");

        // R5: reassert on next out-of-range
        feed(1, 12'hF00); em[1] = 1'b1;
        rdclr(v); chk("R5 read two bits", v, sw(em));
        em[6:0] = '0;
        chk_stat("R5 cleared");
        feed(1, 12'hF00); em[1] = 1'b1; chk_stat("R5 reassert");

        // R6: clear-on-read and new event in the same clock
        rdclr(v); em[6:0] = '0;
        feed(3, 12'hFFF); em[3] = 1'b1; chk_stat("R6 precondition");
        ext_data[2*DW +: DW] = 12'h000; ext_valid[2] = 1'b1;
        reg_addr = 5'd18; reg_rd = 1'b1;
        #0.1;
        chk("R6 read value", reg_rdata, sw(em));
        tick();
        reg_rd = 1'b0; ext_valid = '0;
        em = 8'h04;
        chk_stat("R6 event wins, others clear");

        // R7: transparent mode tracks and ignores reads
        wr(16, 16'h0003);
        chk_stat("R7 mode switch keeps bit");
        feed(2, 12'h200); em[2] = 1'b0; chk_stat("R7 drops on in-range");
        feed(2, 12'h000); em[2] = 1'b1; chk_stat("R7 raise");
        rdclr(v); chk("R7 read value", v, sw(em));
        chk_stat("R7 read does not clear");
        feed(5, 12'h000); em[6] = 1'b1; chk_stat("R3 temp low transparent");
        feed(5, 12'h800); em[6] = 1'b0; chk_stat("R3 temp in range");

        // R6 in transparent mode: read and event together
        ext_data[4*DW +: DW] = 12'hFFF; ext_valid[4] = 1'b1;
        reg_addr = 5'd18; reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0; ext_valid = '0; em[4] = 1'b1;
        chk_stat("R6 transparent clash");

        // R8: alarm input is never latched
        alarm_in = 1'b1; tick(); em[7] = 1'b1; chk_stat("R8 follows high");
        wr(16, 16'h0002);
        rdclr(v); chk("R8 read value", v, sw(em));
        em[6:0] = '0;
        chk_stat("R8 survives read");
        alarm_in = 1'b0; tick(); em[7] = 1'b0; chk_stat("R8 drops unlatched");
        chk_stat("R9 global clear");

        // R10: mask sweep over all patterns
        feed(0, 12'h000); em[0] = 1'b1;
        feed(5, 12'hFFF); em[5] = 1'b1;
        alarm_in = 1'b1; tick(); em[7] = 1'b1;
        for (int m = 0; m < 256; m++) begin
            wr(17, 16'(m));
            chk_irq("R10 mask gating", |(em & ~8'(m)));
            if (m % 16 == 0) chk_stat("R10 mask leaves status");
        end

        // R11: enable gates the interrupt
        wr(17, 16'h0000);
        wr(16, 16'h0000);
        chk_irq("R11 disabled", 1'b0);
        chk_stat("R11 status intact");
        wr(16, 16'h0002);
        chk_irq("R11 enabled", 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule